// File: doc/BRIEF.md
# Complementary Dead-Time Gate Generator

This block produces the two gate-drive enables of a half-bridge. An outer regulation loop supplies a switching period as a count of system-clock cycles. Each period is split into a high-side half followed by a low-side half. Each half begins with a fixed number of cycles in which both enables are low. As a result, the two switches never conduct together, and each one is on for close to half of the period.

After reset, and again each time the shutdown input is released, the block runs a soft-start. The period that is used starts shorter than the commanded value by a fixed number of cycles, which means a higher switching frequency. That shortening shrinks in equal steps at each new period until it reaches zero, and a flag then reports that the sweep is complete. The shutdown input is synchronous and clears both enables at the next clock edge. A floor on the period keeps the switching rate within the supported range: with the default 100 MHz clock, the floor of 320 cycles corresponds to 312.5 kHz.

Top module: `hb_gate_gen`

## Requirements
- R1: While reset is asserted, `hs_on`, `ls_on` and `ss_done` are all low.
- R2: `hs_on` and `ls_on` are never high together. Every rising edge of either enable comes after exactly DEAD consecutive cycles in which both are low; the first pulse after reset or release is covered by R7.
- R3: For a used period of P cycles with H = floor(P/2), the high-side pulse comes first and lasts H-DEAD cycles. The low-side pulse follows and lasts P-H-DEAD cycles, so the two pulse widths never differ by more than one cycle.
- R4: The used period is max(cmd - offset, FLOOR), where FLOOR = max(MIN_PER, 2*DEAD+2). A difference below zero counts as zero.
- R5: The offset is SS_SHORT for the first period after reset or release. It falls by SS_STEP at each later period start and never goes below zero. `ss_done` goes high once the offset is zero and stays high until shutdown.
- R6: When `halt` is sampled high, both enables and `ss_done` are low after that same edge, and they stay low while `halt` is held.
- R7: After `halt` falls, a new period begins at the next edge. Its high-side pulse first appears DEAD+1 edges after the release, and the soft-start restarts at the full offset.
- R8: `period_cmd` is sampled only at a period start. A change made in the middle of a period takes effect at the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt | input | 1 | Synchronous shutdown; high forces both enables low |
| period_cmd | input | PER_W | Commanded switching period in clock cycles |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| ss_done | output | 1 | High once the soft-start offset has reached zero |

## Verification
A shutdown request clears the enables one edge after it is sampled. After a release, the first high-side pulse is due DEAD+1 edges later. Pulse widths and dead gaps only become known once a pulse ends. The bench therefore queues the expected widths of each period in advance and compares them when a low-side pulse falls, which marks the end of a period. All stimulus changes are applied one time unit after a falling edge and all sampling is done on falling edges, so each expected value is read exactly one edge after the register that produces it.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    // Which half of the switching period is active.
    typedef enum logic {
        LEG_HI = 1'b0,
        LEG_LO = 1'b1
    } leg_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/hbg_ramp.sv
// Soft-start offset: loaded on reset/shutdown, stepped down at each period start.
module hbg_ramp #(
    parameter int PER_W    = 14,
    parameter int SS_SHORT = 286,
    parameter int SS_STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             cyc_start,
    output logic [PER_W-1:0] offset,
    output logic             done
);
    localparam logic [PER_W-1:0] SHORT_V = PER_W'(SS_SHORT);
    localparam logic [PER_W-1:0] STEP_V  = PER_W'(SS_STEP);
    localparam logic             ZERO_AT_START = (SS_SHORT == 0);

    typedef struct packed {
        logic [PER_W-1:0] off;
        logic             done;
    } ramp_s;

    ramp_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (halt) begin
            r_d.off  = SHORT_V;
            r_d.done = ZERO_AT_START;
        end else if (cyc_start) begin
            if (r_q.off > STEP_V) begin
                r_d.off = r_q.off - STEP_V;
            end else begin
                r_d.off = '0;
            end
            r_d.done = (r_d.off == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.off  <= SHORT_V;
            r_q.done <= ZERO_AT_START;
        end else begin
            r_q <= r_d;
        end
    end

    assign offset = r_q.off;
    assign done   = r_q.done;
endmodule

// File: rtl/hbg_persel.sv
// Used period: commanded period minus soft-start offset, clamped to a floor.
module hbg_persel #(
    parameter int PER_W   = 14,
    parameter int DEAD    = 35,
    parameter int MIN_PER = 320
) (
    input  logic [PER_W-1:0] cmd,
    input  logic [PER_W-1:0] offset,
    output logic [PER_W-1:0] eff
);
    import hbg_pkg::*;

    localparam int               FLOOR   = imax(MIN_PER, 2 * DEAD + 2);
    localparam logic [PER_W-1:0] FLOOR_V = PER_W'(FLOOR);

    logic [PER_W-1:0] diff;

    always_comb begin
        diff = (cmd > offset) ? (cmd - offset) : '0;
        eff  = (diff < FLOOR_V) ? FLOOR_V : diff;
    end
endmodule

// File: rtl/hbg_leg.sv
// Period sequencer: high half then low half, each opening with DEAD idle cycles.
module hbg_leg #(
    parameter int PER_W = 14,
    parameter int DEAD  = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic [PER_W-1:0] eff_per,
    output logic             cyc_start,
    output logic             hs_on,
    output logic             ls_on
);
    import hbg_pkg::*;

    localparam logic [PER_W-1:0] DEAD_V = PER_W'(DEAD);

    typedef struct packed {
        logic             run;
        leg_e             leg;
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] len;
        logic [PER_W-1:0] per;
        logic             hs;
        logic             ls;
    } leg_s;

    leg_s s_d, s_q;
    logic drive;

    always_comb begin
        s_d       = s_q;
        cyc_start = 1'b0;
        if (halt) begin
            s_d = '0;
        end else if (!s_q.run) begin
            s_d.run   = 1'b1;
            s_d.leg   = LEG_HI;
            s_d.cnt   = '0;
            s_d.per   = eff_per;
            s_d.len   = eff_per >> 1;
            cyc_start = 1'b1;
        end else if (s_q.cnt == s_q.len - 1'b1) begin
            s_d.cnt = '0;
            if (s_q.leg == LEG_HI) begin
                s_d.leg = LEG_LO;
                s_d.len = s_q.per - (s_q.per >> 1);
            end else begin
                s_d.leg   = LEG_HI;
                s_d.per   = eff_per;
                s_d.len   = eff_per >> 1;
                cyc_start = 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        drive  = s_d.run && (s_d.cnt >= DEAD_V);
        s_d.hs = drive && (s_d.leg == LEG_HI);
        s_d.ls = drive && (s_d.leg == LEG_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hs_on = s_q.hs;
    assign ls_on = s_q.ls;
endmodule

// File: rtl/hb_gate_gen.sv
module hb_gate_gen #(
    parameter int PER_W    = 14,
    parameter int DEAD     = 35,
    parameter int MIN_PER  = 320,
    parameter int SS_SHORT = 286,
    parameter int SS_STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic [PER_W-1:0] period_cmd,
    output logic             hs_on,
    output logic             ls_on,
    output logic             ss_done
);
    logic             cyc_start;
    logic [PER_W-1:0] offset;
    logic [PER_W-1:0] eff_per;

    hbg_ramp #(
        .PER_W   (PER_W),
        .SS_SHORT(SS_SHORT),
        .SS_STEP (SS_STEP)
    ) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt),
        .cyc_start(cyc_start),
        .offset   (offset),
        .done     (ss_done)
    );

    hbg_persel #(
        .PER_W  (PER_W),
        .DEAD   (DEAD),
        .MIN_PER(MIN_PER)
    ) u_sel (
        .cmd   (period_cmd),
        .offset(offset),
        .eff   (eff_per)
    );

    hbg_leg #(
        .PER_W(PER_W),
        .DEAD (DEAD)
    ) u_leg (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt),
        .eff_per  (eff_per),
        .cyc_start(cyc_start),
        .hs_on    (hs_on),
        .ls_on    (ls_on)
    );
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk #(
    parameter int DEAD = 35
) (
    input logic clk,
    input logic rst_n,
    input logic halt,
    input logic hs_on,
    input logic ls_on,
    input logic ss_done
);
    localparam int           GW     = $clog2(DEAD + 2) + 1;
    localparam logic [GW-1:0] DEAD_G = GW'(DEAD);
    localparam logic [GW-1:0] SAT_G  = GW'(DEAD + 1);

    // Consecutive sampled cycles with both enables low, saturating.
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (hs_on || ls_on) begin
            gap_q <= '0;
        end else if (gap_q < SAT_G) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    p_dead_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_on) || $rose(ls_on)) |-> (gap_q >= DEAD_G));

    p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!hs_on && !ls_on && !ss_done));

    p_done_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && !halt) |=> ss_done);

    p_release_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt) |-> (!hs_on && !ls_on));
endmodule

bind hb_gate_gen hbg_chk #(.DEAD(DEAD)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt   (halt),
    .hs_on  (hs_on),
    .ls_on  (ls_on),
    .ss_done(ss_done)
);

// File: tb/sim_hb_gate_gen.sv
module sim_hb_gate_gen;
    localparam int CLK_PERIOD = 10;
    localparam int PER_W    = 10;
    localparam int DEAD     = 4;
    localparam int MIN_PER  = 24;
    localparam int SS_SHORT = 40;
    localparam int SS_STEP  = 10;
    localparam int FLOOR    = (MIN_PER > 2 * DEAD + 2) ? MIN_PER : 2 * DEAD + 2;

    typedef struct {
        int    hs_w;
        int    ls_w;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             halt;
    logic [PER_W-1:0] period_cmd;
    logic             hs_on, ls_on, ss_done;

    int   total = 0;
    int   bad   = 0;
    exp_t q[$];
    bit   mon_en = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hb_gate_gen #(
        .PER_W   (PER_W),
        .DEAD    (DEAD),
        .MIN_PER (MIN_PER),
        .SS_SHORT(SS_SHORT),
        .SS_STEP (SS_STEP)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .period_cmd(period_cmd),
        .hs_on     (hs_on),
        .ls_on     (ls_on),
        .ss_done   (ss_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected pulse widths of the k-th period after a (re)start.
    task automatic push_cyc(input int k, input int cmd, input string tag);
        int   off;
        int   p;
        exp_t e;
        off = SS_SHORT - k * SS_STEP;
        if (off < 0) off = 0;
        p = cmd - off;
        if (p < FLOOR) p = FLOOR;
        e.hs_w = p / 2 - DEAD;
        e.ls_w = p - p / 2 - DEAD;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic drain();
        while (q.size() != 0) step();
    endtask

    // Monitor: measures pulse widths and dead gaps at falling edges.
    int hs_run = 0, ls_run = 0, hs_len = 0, gap = 0;
    bit hs_p = 1'b0, ls_p = 1'b0, armed = 1'b0;

    always @(negedge clk) begin
        if (!mon_en) begin
            hs_run = 0; ls_run = 0; gap = 0; armed = 1'b0;
            hs_p = hs_on; ls_p = ls_on;
        end else begin
            if (hs_on && ls_on) chk(1'b0, "R2", "overlap", 1, 0);
            if (((hs_on && !hs_p) || (ls_on && !ls_p)) && armed)
                chk(gap == DEAD, "R2", "dead gap", gap, DEAD);
            if (!hs_on && !ls_on) gap = (hs_p || ls_p) ? 1 : gap + 1;
            if (hs_on) hs_run++;
            else if (hs_p) begin
                hs_len = hs_run; hs_run = 0; armed = 1'b1;
            end
            if (ls_on) ls_run++;
            else if (ls_p) begin
                armed = 1'b1;
                if (q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected period", ls_run, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(hs_len == e.hs_w, e.tag, "high-side width", hs_len, e.hs_w);
                    chk(ls_run == e.ls_w, e.tag, "low-side width", ls_run, e.ls_w);
                end
                ls_run = 0;
            end
            hs_p = hs_on; ls_p = ls_on;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int  first;
        bit  quiet;
        rst_n      = 1'b0;
        halt       = 1'b0;
        period_cmd = PER_W'(100);
        repeat (3) step();
        // R1: reset state
        chk(!hs_on && !ls_on, "R1", "enables in reset", {hs_on, ls_on}, 0);
        chk(!ss_done, "R1", "done in reset", ss_done, 0);

        // R3 R4 R5: soft-start sweep then steady periods of 100
        for (int k = 0; k < 7; k++) push_cyc(k, 100, "R4");
        rst_n = 1'b1;
        drain();
        chk(ss_done, "R5", "done after sweep", ss_done, 1);

        // R8: mid-period change; the running period keeps 100
        period_cmd = PER_W'(60);
        push_cyc(99, 100, "R8");
        for (int k = 0; k < 3; k++) push_cyc(99, 60, "R8");
        drain();

        // R6: shutdown during a high-side pulse
        mon_en = 1'b0;
        while (!hs_on) step();
        halt = 1'b1;
        step();
        chk(!hs_on && !ls_on, "R6", "enables after halt", {hs_on, ls_on}, 0);
        chk(!ss_done, "R6", "done after halt", ss_done, 0);
        quiet = 1'b1;
        for (int i = 0; i < 15; i++) begin
            step();
            if (hs_on || ls_on) quiet = 1'b0;
        end
        chk(quiet, "R6", "held low during halt", !quiet, 0);

        // R7: release with odd period 101, full soft-start again (R3 odd split)
        period_cmd = PER_W'(101);
        for (int k = 0; k < 6; k++) push_cyc(k, 101, "R3");
        mon_en = 1'b1;
        halt   = 1'b0;
        first  = 0;
        for (int i = 1; i <= 3 * DEAD; i++) begin
            step();
            if (i == 1) chk(!ss_done, "R7", "sweep restarted", ss_done, 0);
            if (hs_on && first == 0) first = i;
        end
        chk(first == DEAD + 1, "R7", "first pulse edge", first, DEAD + 1);
        drain();

        // R4: command below the floor
        mon_en = 1'b0;
        halt   = 1'b1;
        step();
        period_cmd = PER_W'(10);
        for (int k = 0; k < 4; k++) push_cyc(k, 10, "R4");
        mon_en = 1'b1;
        halt   = 1'b0;
        drain();
        chk(ss_done, "R5", "done after floor run", ss_done, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule